// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit treats a 64-bit operand pair as a row of equal-width packed lanes and applies one operation to every lane at once. A two-bit size code picks 8-, 16- or 32-bit lanes, or the whole 64-bit word for bitwise logic. Add and subtract can wrap, saturate as signed values or saturate as unsigned values. Equality and signed greater-than compares turn each lane into an all-ones or all-zeros mask, so later selection can use plain logic and needs no branch.

Operands, opcode and size are sampled together with a valid strobe. The result and its valid flag appear on registered outputs one clock later. The result register loads only on a strobe, so an idle cycle leaves the last result in place.

Top module: `packed_simd_alu`

## Requirements
- R1: Opcodes 0 (add) and 3 (subtract) wrap modulo 2^W within each lane for size codes 0, 1 and 2 (W = 8, 16, 32). No carry or borrow crosses a lane boundary.
- R2: Opcodes 1 (add) and 4 (subtract) treat lanes as two's-complement values for size codes 0 and 1. A result past the range is clamped to the lane's signed maximum or minimum.
- R3: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned values for size codes 0 and 1. A result above the lane's all-ones value becomes all ones, and a result below zero becomes zero.
- R4: Opcode 6 sets each lane to all ones when its two operand lanes are equal, and to all zeros otherwise, for size codes 0, 1 and 2.
- R5: Opcode 7 sets each lane to all ones when the first operand lane is greater than the second as signed values, and to all zeros otherwise, for size codes 0, 1 and 2.
- R6: Opcodes 8 (a AND b), 9 ((NOT a) AND b), 10 (a OR b) and 11 (a XOR b) act on all 64 bits. The result does not depend on the size code.
- R7: The result is zero in three cases: size code 3 with any opcode below 8, opcodes 1, 2, 4 and 5 with size code 2, and opcodes 12 to 15.
- R8: A result with valid_o high appears exactly one clock after a cycle with valid_i high. valid_o is low after a cycle with valid_i low, and result_o then keeps its value.
- R9: A synchronous active-high reset clears valid_o and result_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode (see R1 to R7) |
| size_i | input | 2 | Lane size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result valid, one clock after valid_i |
| result_o | output | 64 | Registered packed result |

## Verification
The risky coincidence is a saturating clamp in one lane while the neighbouring lane produces a carry or borrow that must not spill over. The bench provokes this with operands that drive alternating lanes past their limits, such as 0x7F next to 0xFF in byte lanes, under every add and subtract mode. Each lane of the registered result is compared with a lane-by-lane model built from the requirements. Back-to-back strobes are also interleaved with idle gaps, to show that a new result and the hold of an old one never mix in the same cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDS  = 4'd1,
    OP_ADDUS = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBS  = 4'd4,
    OP_SUBUS = 4'd5,
    OP_CEQ   = 4'd6,
    OP_CGT   = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } lane_sz_e;

  function automatic logic op_is_logic(input simd_op_e op);
    return (op == OP_AND) || (op == OP_ANDN) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_sat(input simd_op_e op);
    return (op == OP_ADDS) || (op == OP_ADDUS) || (op == OP_SUBS) || (op == OP_SUBUS);
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  simd_op_e     op,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum_w;
  logic [W:0] dif_w;
  logic       sovf_add;
  logic       sovf_sub;
  logic [W-1:0] sclamp;

  always_comb begin
    sum_w    = {1'b0, a} + {1'b0, b};
    dif_w    = {1'b0, a} - {1'b0, b};
    sovf_add = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);
    sovf_sub = (a[W-1] != b[W-1]) && (dif_w[W-1] != a[W-1]);
    sclamp   = a[W-1] ? SMIN : SMAX;
  end

  always_comb begin
    case (op)
      OP_ADD:   y = sum_w[W-1:0];
      OP_SUB:   y = dif_w[W-1:0];
      OP_ADDS:  y = sovf_add ? sclamp : sum_w[W-1:0];
      OP_SUBS:  y = sovf_sub ? sclamp : dif_w[W-1:0];
      OP_ADDUS: y = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];
      OP_SUBUS: y = dif_w[W] ? {W{1'b0}} : dif_w[W-1:0];
      OP_CEQ:   y = {W{a == b}};
      OP_CGT:   y = {W{$signed(a) > $signed(b)}};
      default:  y = '0;
    endcase
  end

  always_comb begin
    // R3
    if (op == OP_ADDUS) usat_add_chk: assert (y >= a);
    // R3
    if (op == OP_SUBUS) usat_sub_chk: assert (y <= a);
    // R2
    if (op == OP_ADDS && a[W-1] == b[W-1]) ssat_add_chk: assert (y[W-1] == a[W-1]);
  end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  simd_op_e          op,
  output logic [DATA_W-1:0] y
);

  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .a  (a[i*LANE_W +: LANE_W]),
      .b  (b[i*LANE_W +: LANE_W]),
      .op (op),
      .y  (y[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  simd_op_e          op,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_ANDN: y = ~a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/packed_simd_alu.sv
module packed_simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int MIN_LANE_W = 8,
  parameter int SAT_MAX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int NUM_SZ = 3;

  simd_op_e          op;
  logic [DATA_W-1:0] res_sz [NUM_SZ];
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] res_next;
  logic [NUM_SZ-1:0] sat_ok;

  assign op = simd_op_e'(op_i);

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
    localparam int LW = MIN_LANE_W << g;
    assign sat_ok[g] = (LW <= SAT_MAX_W);
    simd_lane_array #(.DATA_W(DATA_W), .LANE_W(LW)) u_arr (
      .a  (a_i),
      .b  (b_i),
      .op (op),
      .y  (res_sz[g])
    );
  end

  simd_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a  (a_i),
    .b  (b_i),
    .op (op),
    .y  (logic_y)
  );

  always_comb begin
    if (op_is_logic(op)) begin
      res_next = logic_y;
    end else if (size_i == SZ_64) begin
      res_next = '0;
    end else if (op_is_sat(op) && !sat_ok[size_i]) begin
      res_next = '0;
    end else begin
      res_next = res_sz[size_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_next;
    end
  end

  // R8
  lat_chk: assert property (@(posedge clk) disable iff (rst) valid_i |=> valid_o);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst) !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_i |=> $stable(result_o));
  // R9
  rst_chk: assert property (@(posedge clk) rst |=> (!valid_o && result_o == '0));
  // R7
  wide_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == SZ_64 && op_i < 4'd8) |=> (result_o == '0));

endmodule

// File: tb/packed_simd_alu_bench.sv
module packed_simd_alu_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  item_t       sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_exp = '0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_simd_alu u_packed_simd_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, int op, int sz);
    logic [63:0] r = '0;
    int w = 8 << sz;
    longint m, ua, ub, sa, sb, v, hi, lo;
    if (op == 8)  return a & b;
    if (op == 9)  return ~a & b;
    if (op == 10) return a | b;
    if (op == 11) return a ^ b;
    if (op > 11 || sz == 3) return '0;
    if ((op == 1 || op == 2 || op == 4 || op == 5) && sz == 2) return '0;
    m  = (longint'(1) << w) - 1;
    hi = (longint'(1) << (w-1)) - 1;
    lo = -(longint'(1) << (w-1));
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'((a >> (i*w))) & m;
      ub = longint'((b >> (i*w))) & m;
      sa = (ua > hi) ? ua - m - 1 : ua;
      sb = (ub > hi) ? ub - m - 1 : ub;
      case (op)
        0: v = (ua + ub) & m;
        3: v = (ua - ub) & m;
        1: begin v = sa + sb; v = (v > hi) ? hi : (v < lo) ? lo : v; v = v & m; end
        4: begin v = sa - sb; v = (v > hi) ? hi : (v < lo) ? lo : v; v = v & m; end
        2: begin v = ua + ub; if (v > m) v = m; end
        5: begin v = ua - ub; if (v < 0) v = 0; end
        6: v = (ua == ub) ? m : 0;
        default: v = (sa > sb) ? m : 0;
      endcase
      r = r | (64'(v) << (i*w));
    end
    return r;
  endfunction

  function automatic string tag_of(int op, int sz);
    if (op > 11 || (sz == 3 && op < 8)) return "R7";
    if ((op == 1 || op == 2 || op == 4 || op == 5) && sz == 2) return "R7";
    case (op)
      0, 3: return "R1";
      1, 4: return "R2";
      2, 5: return "R3";
      6: return "R4";
      7: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, int op, int sz);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; op_i = 4'(op); size_i = 2'(sz); valid_i = 1'b1;
    it.exp = model(a, b, op, sz);
    it.tag = tag_of(op, sz);
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: actual valid_o 1 expected 0 (no pending item)");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, result_o, it.exp);
        last_exp = it.exp;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {63'd0, valid_o}, 64'd0);
    check("R9", result_o, 64'd0);
    rst = 1'b0;

    // R1 wrap with carries at lane edges
    send(64'h00FF_7F80_FFFF_0001, 64'h0001_0180_0001_FFFF, 0, 0);
    send(64'h00FF_7F80_FFFF_0001, 64'h0001_0180_0001_FFFF, 0, 1);
    send(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 3, 2);
    send(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 3, 0);
    // R2 signed clamps next to non-saturating lanes
    send(64'h7F80_7F80_0110_7F01, 64'h0180_7F80_0101_0101, 1, 0);
    send(64'h7FFF_8000_1234_8001, 64'h0001_FFFF_0001_0002, 1, 1);
    send(64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0003_8000, 4, 1);
    send(64'h807F_0000_0000_0000, 64'h017F_01FF_0000_0000, 4, 0);
    // R3 unsigned clamps
    send(64'hFF01_FFFE_8080_0000, 64'h0101_0001_8080_0001, 2, 0);
    send(64'hFFFF_0001_8000_0000, 64'h0001_0001_8000_0001, 2, 1);
    send(64'h0001_0005_0100_0000, 64'h0002_0003_0001_0001, 5, 1);
    send(64'h0105_FF00_0000_0000, 64'h0203_0101_0000_0000, 5, 0);
    // R4 / R5 compares
    send(64'h1122_3344_5566_7788, 64'h1122_0044_5566_7700, 6, 0);
    send(64'h1122_3344_5566_7788, 64'h1122_3344_0000_7788, 6, 2);
    send(64'h7F80_0001_FFFF_8000, 64'h807F_0001_0000_7FFF, 7, 0);
    send(64'h7F80_0001_FFFF_8000, 64'h807F_0001_0000_7FFF, 7, 1);
    send(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 7, 2);
    // R6 logic at all size codes
    for (int s = 0; s < 4; s++) begin
      send(64'hF0F0_1234_AAAA_0F0F, 64'hFF00_4321_5555_00FF, 8 + s, s);
    end
    // R7 zero cases
    send(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0, 3);
    send(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 7, 3);
    send(64'h7FFF_FFFF_0000_0001, 64'h7FFF_FFFF_0000_0001, 1, 2);
    send(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 5, 2);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 13, 0);
    idle(3);

    // R8 hold: idle cycles keep last result, valid low
    check("R8", {63'd0, valid_o}, 64'd0);
    check("R8", result_o, last_exp);

    // random mix with gaps
    for (int k = 0; k < 300; k++) begin
      send({$urandom, $urandom}, {$urandom, $urandom}, int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    check("R8", result_o, last_exp);

    // R9 mid-run reset
    send(64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 10, 0);
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", {63'd0, valid_o}, 64'd0);
    check("R9", result_o, 64'd0);
    idle(2);
    check("R8", {63'd0, 32'(sb_q.size()), valid_o}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule